// File: doc/BRIEF.md
# Thread Context Ring Matcher

This block decides whether an incoming interrupt notification is aimed at one hardware thread, and if so, on which privilege ring. The notification carries a format bit, an ignore flag, a target block and index, and a logical-server identifier. The thread's context words, which are written elsewhere and presented here as plain inputs, hold a valid bit and a match field for each of four rings: physical hypervisor, pool hypervisor, operating system and user.

Two kinds of content-addressable line are compared. The physical ring uses a hardwired line built from a chip number and a thread number, packed in one of two layouts chosen by a static grouping input. The pool and OS rings use a virtual line that concatenates the block above the index. The format bit selects the search. Format 0 walks the physical, pool and OS rings and reports the first hit. Format 1 looks only at the user ring. A format-0 request with the ignore flag set asks for logical-server arbitration, which this block does not do, so it raises an unsupported flag instead of a hit.

The thread's processor ID is sampled once after reset and is held from then on. The match result is combinational from the request and context inputs.

Top module: `thread_ring_match`

## Requirements
- R1: The processor ID is captured on the first clock edge after the internal reset is released and is held from then on. Later changes on `pid_i` have no effect on matching.
- R2: The physical ring hits, with ring code 3, when `phys_vld_i` is 1 and the hardwired line of the thread equals the hardwired line of the request. The thread's chip is `pid[11:8]` and its thread number is `pid[6:0]`. The request's chip is `blk_i[3:0]` and its thread number is `idx_i[6:0]`. The upper index bits take no part.
- R3: The hardwired line is 15 bits wide. With `grp_en_i` at 0 it places the chip at bits 14:11, a 1 at bit 7 and the thread number at bits 6:0. With `grp_en_i` at 1 it places a 1 at bit 11, the chip at bits 10:7 and the thread number at bits 6:0. Both sides of the compare use the same layout.
- R4: The pool ring hits, with ring code 2, when `pool_vld_i` is 1 and `pool_cam_i` equals `{blk_i, idx_i}`, that is the block shifted left by the index width and ORed with the index.
- R5: The OS ring hits, with ring code 1, when `os_vld_i` is 1 and `os_cam_i` equals `{blk_i, idx_i}`.
- R6: With `fmt_i` at 0 and `ign_i` at 0, the priority order is physical, then pool, then OS, and only the highest-priority hit is reported.
- R7: With `fmt_i` at 1, only the user ring is considered, and it reports ring code 0. It hits when `os_vld_i` is 1, `os_cam_i` matches the virtual line, `user_vld_i` is 1 and `user_ls_i` equals `ls_i`. Hits on the physical and pool rings are ignored. `ign_i` has no effect in this format.
- R8: With `fmt_i` at 0 and `ign_i` at 1, `unsup_o` is 1 and `hit_o` is 0. In every other case `unsup_o` is 0.
- R9: When no ring hits, `hit_o` is 0 and `ring_o` is 0. This also holds right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grp_en_i | input | 1 | Static selector for the hardwired-line layout |
| pid_i | input | 12 | Processor ID of this thread, sampled after reset |
| fmt_i | input | 1 | Request format: 0 selects the hypervisor and OS rings, 1 selects the user ring |
| ign_i | input | 1 | Ignore flag that marks a logical-server request |
| blk_i | input | BLK_W | Target block |
| idx_i | input | IDX_W | Target index |
| ls_i | input | LS_W | Requested logical-server ID |
| phys_vld_i | input | 1 | Physical ring valid bit |
| pool_vld_i | input | 1 | Pool ring valid bit |
| pool_cam_i | input | BLK_W+IDX_W | Pool ring stored line |
| os_vld_i | input | 1 | OS ring valid bit |
| os_cam_i | input | BLK_W+IDX_W | OS ring stored line |
| user_vld_i | input | 1 | User ring valid bit |
| user_ls_i | input | LS_W | User ring stored logical-server ID |
| hit_o | output | 1 | A ring matched |
| ring_o | output | 2 | Code of the matching ring: 0 user, 1 OS, 2 pool, 3 physical |
| unsup_o | output | 1 | The request needs logical-server arbitration and is not served |

## Verification
The bench makes several rings match at the same time. A design with the wrong priority would report pool or OS where physical must win. It sets the upper index bits and toggles the grouping layout on a physical match. A design that compared the whole index, or built the two sides in different layouts, would lose that hit. Format 1 is driven while the physical and pool rings match, and again with only the logical-server field differing. A leaky design would report a hypervisor ring, or a user hit on a wrong server. It also changes the processor ID after capture, so a design that tracked the live pin would match the wrong thread.

// File: rtl/tm_pkg.sv
package tm_pkg;
  localparam int CHIP_W       = 4;
  localparam int TID_W        = 7;
  localparam int PID_W        = 12;
  localparam int PID_CHIP_LSB = 8;
  localparam int HCAM_W       = 15;
  localparam int NUM_RINGS    = 4;

  typedef enum logic [1:0] {
    RING_USER = 2'd0,
    RING_OS   = 2'd1,
    RING_POOL = 2'd2,
    RING_PHYS = 2'd3
  } ring_e;

  // Hardwired line: two layouts selected by the grouping option
  function automatic logic [HCAM_W-1:0] hw_line(input logic grp,
                                                input logic [CHIP_W-1:0] chip,
                                                input logic [TID_W-1:0] tid);
    if (grp) return {3'b000, 1'b1, chip, tid};
    else     return {chip, 3'b000, 1'b1, tid};
  endfunction
endpackage

// File: rtl/tm_cam_gen.sv
module tm_cam_gen
  import tm_pkg::*;
#(
  parameter int BLK_W = 4,
  parameter int IDX_W = 19,
  localparam int VCAM_W = BLK_W + IDX_W
) (
  input  logic              grp_en,
  input  logic [PID_W-1:0]  pid,
  input  logic [BLK_W-1:0]  blk,
  input  logic [IDX_W-1:0]  idx,
  output logic [VCAM_W-1:0] vline,
  output logic [HCAM_W-1:0] hline_self,
  output logic [HCAM_W-1:0] hline_req
);
  logic [CHIP_W-1:0] self_chip;
  logic [TID_W-1:0]  self_tid;

  always_comb begin
    self_chip  = pid[PID_CHIP_LSB +: CHIP_W];
    self_tid   = pid[TID_W-1:0];
    vline      = {blk, idx};
    hline_self = hw_line(grp_en, self_chip, self_tid);
    hline_req  = hw_line(grp_en, blk[CHIP_W-1:0], idx[TID_W-1:0]);
  end
endmodule

// File: rtl/tm_ring_eval.sv
module tm_ring_eval
  import tm_pkg::*;
#(
  parameter int VCAM_W = 23,
  parameter int LS_W   = 31
) (
  input  logic [HCAM_W-1:0]    hline_self,
  input  logic [HCAM_W-1:0]    hline_req,
  input  logic [VCAM_W-1:0]    vline,
  input  logic [LS_W-1:0]      ls,
  input  logic                 phys_vld,
  input  logic                 pool_vld,
  input  logic [VCAM_W-1:0]    pool_cam,
  input  logic                 os_vld,
  input  logic [VCAM_W-1:0]    os_cam,
  input  logic                 user_vld,
  input  logic [LS_W-1:0]      user_ls,
  output logic [NUM_RINGS-1:0] ring_hit
);
  logic os_hit;

  always_comb begin
    os_hit              = os_vld && (os_cam == vline);
    ring_hit[RING_PHYS] = phys_vld && (hline_self == hline_req);
    ring_hit[RING_POOL] = pool_vld && (pool_cam == vline);
    ring_hit[RING_OS]   = os_hit;
    ring_hit[RING_USER] = os_hit && user_vld && (user_ls == ls);
  end
endmodule

// File: rtl/tm_prio_sel.sv
module tm_prio_sel
  import tm_pkg::*;
(
  input  logic                 fmt,
  input  logic                 ign,
  input  logic [NUM_RINGS-1:0] ring_hit,
  output logic                 hit,
  output ring_e                ring,
  output logic                 unsup
);
  always_comb begin
    hit   = 1'b0;
    ring  = RING_USER;
    unsup = 1'b0;
    if (!fmt && ign) begin
      unsup = 1'b1;
    end else if (fmt) begin
      hit = ring_hit[RING_USER];
    end else begin
      // ascending walk: the last (highest) hit wins
      for (int i = 1; i < NUM_RINGS; i++) begin
        if (ring_hit[i]) begin
          hit  = 1'b1;
          ring = ring_e'(i[1:0]);
        end
      end
    end
  end
endmodule

// File: rtl/thread_ring_match.sv
module thread_ring_match
  import tm_pkg::*;
#(
  parameter int BLK_W = 4,
  parameter int IDX_W = 19,
  parameter int LS_W  = 31,
  localparam int VCAM_W = BLK_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grp_en_i,
  input  logic [PID_W-1:0]  pid_i,
  input  logic              fmt_i,
  input  logic              ign_i,
  input  logic [BLK_W-1:0]  blk_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [LS_W-1:0]   ls_i,
  input  logic              phys_vld_i,
  input  logic              pool_vld_i,
  input  logic [VCAM_W-1:0] pool_cam_i,
  input  logic              os_vld_i,
  input  logic [VCAM_W-1:0] os_cam_i,
  input  logic              user_vld_i,
  input  logic [LS_W-1:0]   user_ls_i,
  output logic              hit_o,
  output logic [1:0]        ring_o,
  output logic              unsup_o
);
  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // one-shot capture of the processor ID
  logic             cap_q, cap_d, cap_en;
  logic [PID_W-1:0] pid_q, pid_d;

  always_comb begin
    cap_en = !cap_q;
    cap_d  = 1'b1;
    pid_d  = pid_i;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cap_q <= 1'b0;
      pid_q <= '0;
    end else if (cap_en) begin
      cap_q <= cap_d;
      pid_q <= pid_d;
    end
  end

  logic [VCAM_W-1:0]    vline;
  logic [HCAM_W-1:0]    hline_self, hline_req;
  logic [NUM_RINGS-1:0] ring_hit;
  ring_e                ring_sel;
  logic                 unused_pid_bit;

  assign unused_pid_bit = pid_q[7];

  tm_cam_gen #(.BLK_W(BLK_W), .IDX_W(IDX_W)) u_cam (
    .grp_en     (grp_en_i),
    .pid        (pid_q),
    .blk        (blk_i),
    .idx        (idx_i),
    .vline      (vline),
    .hline_self (hline_self),
    .hline_req  (hline_req)
  );

  tm_ring_eval #(.VCAM_W(VCAM_W), .LS_W(LS_W)) u_eval (
    .hline_self (hline_self),
    .hline_req  (hline_req),
    .vline      (vline),
    .ls         (ls_i),
    .phys_vld   (phys_vld_i),
    .pool_vld   (pool_vld_i),
    .pool_cam   (pool_cam_i),
    .os_vld     (os_vld_i),
    .os_cam     (os_cam_i),
    .user_vld   (user_vld_i),
    .user_ls    (user_ls_i),
    .ring_hit   (ring_hit)
  );

  tm_prio_sel u_sel (
    .fmt      (fmt_i),
    .ign      (ign_i),
    .ring_hit (ring_hit),
    .hit      (hit_o),
    .ring     (ring_sel),
    .unsup    (unsup_o)
  );

  assign ring_o = ring_sel;
endmodule

// File: rtl/tm_checker.sv
module tm_checker #(
  parameter int BLK_W = 4,
  parameter int IDX_W = 19,
  localparam int VCAM_W = BLK_W + IDX_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fmt_i,
  input logic              ign_i,
  input logic [BLK_W-1:0]  blk_i,
  input logic [IDX_W-1:0]  idx_i,
  input logic              phys_vld_i,
  input logic              pool_vld_i,
  input logic              os_vld_i,
  input logic [VCAM_W-1:0] os_cam_i,
  input logic              user_vld_i,
  input logic              hit_o,
  input logic [1:0]        ring_o,
  input logic              unsup_o,
  input logic              cap_q,
  input logic [11:0]       pid_q
);
  p_pid_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cap_q |=> $stable(pid_q));

  p_phys_vld_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o && ring_o == 2'd3) |-> phys_vld_i);

  p_pool_vld_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o && ring_o == 2'd2) |-> pool_vld_i);

  p_os_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o && ring_o == 2'd1) |-> (os_vld_i && os_cam_i == {blk_i, idx_i}));

  p_fmt0_ring_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o && !fmt_i) |-> (ring_o != 2'd0));

  p_user_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o && fmt_i) |-> (ring_o == 2'd0 && user_vld_i && os_vld_i));

  p_unsup_r8: assert property (@(posedge clk) disable iff (!rst_n)
    unsup_o |-> (!hit_o && !fmt_i && ign_i));

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_o |-> (ring_o == 2'd0));
endmodule

bind thread_ring_match tm_checker #(.BLK_W(BLK_W), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fmt_i      (fmt_i),
  .ign_i      (ign_i),
  .blk_i      (blk_i),
  .idx_i      (idx_i),
  .phys_vld_i (phys_vld_i),
  .pool_vld_i (pool_vld_i),
  .os_vld_i   (os_vld_i),
  .os_cam_i   (os_cam_i),
  .user_vld_i (user_vld_i),
  .hit_o      (hit_o),
  .ring_o     (ring_o),
  .unsup_o    (unsup_o),
  .cap_q      (cap_q),
  .pid_q      (pid_q)
);

// File: tb/sim_thread_ring_match.sv
module sim_thread_ring_match;
  localparam int BLK_W = 4;
  localparam int IDX_W = 19;
  localparam int LS_W  = 31;
  localparam int VW    = BLK_W + IDX_W;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             grp_en_i;
  logic [11:0]      pid_i;
  logic             fmt_i, ign_i;
  logic [BLK_W-1:0] blk_i;
  logic [IDX_W-1:0] idx_i;
  logic [LS_W-1:0]  ls_i;
  logic             phys_vld_i, pool_vld_i, os_vld_i, user_vld_i;
  logic [VW-1:0]    pool_cam_i, os_cam_i;
  logic [LS_W-1:0]  user_ls_i;
  logic             hit_o, unsup_o;
  logic [1:0]       ring_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  logic [11:0] pid_ref;

  always #2 clk = ~clk;

  thread_ring_match #(.BLK_W(BLK_W), .IDX_W(IDX_W), .LS_W(LS_W)) u0 (.*);

  function automatic logic [14:0] line_of(input logic g, input logic [3:0] c, input logic [6:0] t);
    return g ? {3'b000, 1'b1, c, t} : {c, 3'b000, 1'b1, t};
  endfunction

  // expected {hit, ring, unsup}
  function automatic logic [3:0] model();
    logic hm, pm, om, um;
    hm = phys_vld_i && (line_of(grp_en_i, pid_ref[11:8], pid_ref[6:0]) ==
                        line_of(grp_en_i, blk_i[3:0], idx_i[6:0]));
    pm = pool_vld_i && (pool_cam_i == {blk_i, idx_i});
    om = os_vld_i && (os_cam_i == {blk_i, idx_i});
    um = om && user_vld_i && (user_ls_i == ls_i);
    if (!fmt_i && ign_i) return 4'b0001;
    if (fmt_i)           return um ? 4'b1000 : 4'b0000;
    if (hm) return 4'b1110;
    if (pm) return 4'b1100;
    if (om) return 4'b1010;
    return 4'b0000;
  endfunction

  task automatic check(input string tag, input logic [3:0] exp);
    logic [3:0] act;
    act = {hit_o, ring_o, unsup_o};
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {hit,ring,unsup} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic clear_ctx();
    fmt_i = 0; ign_i = 0; blk_i = '0; idx_i = '0; ls_i = '0;
    phys_vld_i = 0; pool_vld_i = 0; os_vld_i = 0; user_vld_i = 0;
    pool_cam_i = '0; os_cam_i = '0; user_ls_i = '0;
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd7321));
    rst_n = 1'b0; grp_en_i = 1'b0; pid_i = 12'h3A5; pid_ref = 12'h3A5;
    clear_ctx();
    repeat (3) @(negedge clk);
    #1;
    check("R9 reset idle", 4'b0000);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    pid_i = 12'h000;              // R1: later changes must be ignored

    // R2: chip 3, thread 0x25, upper index bits set
    blk_i = 4'h3; idx_i = 19'h12A5 & 19'h7FF7F | 19'h00025; idx_i[6:0] = 7'h25;
    phys_vld_i = 1;
    settle(); check("R2 physical hit", 4'b1110);
    // R3: other layout still hits
    grp_en_i = 1; settle(); check("R3 grouped layout", 4'b1110);
    blk_i = 4'h4; settle(); check("R3 chip mismatch", 4'b0000);
    grp_en_i = 0;
    // R1: live pin now 0; thread 0/0 must not hit
    blk_i = 4'h0; idx_i = '0; settle(); check("R1 pid held", 4'b0000);

    // R4 pool only
    clear_ctx(); blk_i = 4'h5; idx_i = 19'h12345;
    pool_vld_i = 1; pool_cam_i = {4'h5, 19'h12345};
    settle(); check("R4 pool hit", 4'b1100);
    // R5 os only
    pool_vld_i = 0; os_vld_i = 1; os_cam_i = {4'h5, 19'h12345};
    settle(); check("R5 os hit", 4'b1010);
    // R6 priority
    pool_vld_i = 1; settle(); check("R6 pool over os", 4'b1100);
    blk_i = 4'h3; idx_i = 19'h00025;
    pool_cam_i = {4'h3, 19'h00025}; os_cam_i = {4'h3, 19'h00025}; phys_vld_i = 1;
    settle(); check("R6 physical first", 4'b1110);

    // R7 user ring in format 1
    fmt_i = 1; user_vld_i = 1; ls_i = 31'h1234567; user_ls_i = 31'h1234567;
    settle(); check("R7 user hit", 4'b1000);
    user_ls_i = 31'h1234566; settle(); check("R7 server mismatch", 4'b0000);
    ign_i = 1; user_ls_i = 31'h1234567; settle(); check("R7 ignore flag no effect", 4'b1000);

    // R8 logical-server request
    fmt_i = 0; settle(); check("R8 unsupported", 4'b0001);

    // R9 nothing valid
    clear_ctx(); settle(); check("R9 no match", 4'b0000);

    // random mix
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      r = $urandom(); fmt_i = r[0]; ign_i = (r[2:1] == 2'b00); grp_en_i = r[3];
      phys_vld_i = r[4]; pool_vld_i = r[5]; os_vld_i = r[6]; user_vld_i = r[7];
      r = $urandom(); blk_i = r[3:0]; idx_i = r[22:4];
      if (r[23]) begin blk_i = pid_ref[11:8]; idx_i[6:0] = pid_ref[6:0]; end
      r = $urandom(); ls_i = r[30:0];
      r = $urandom(); pool_cam_i = r[31] ? {blk_i, idx_i} : r[VW-1:0];
      r = $urandom(); os_cam_i = r[31] ? {blk_i, idx_i} : r[VW-1:0];
      r = $urandom(); user_ls_i = r[31] ? ls_i : r[30:0];
      #1;
      check("random R2 R3 R4 R5 R6 R7 R8 R9", model());
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule